// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a programmable interval timer. It holds a 32-bit down-counter clocked by a tick. The tick comes from the bus clock through a prescaler that divides by 1, 2, 4 or 8. Software programs a control word, a count value and a reload value over a small register bus.

Each time the count steps from one to zero, the block pulses an interrupt line for one bus-clock cycle. In periodic mode the count restarts from the reload value on the tick after it reaches zero. In one-shot mode the count parks at zero and a sticky terminal-count flag is set. Any permitted access to the control word, read or write, clears that flag. An access-enable bit decides whether requests marked as user-level may touch the registers at all.

Register addresses on `bus_addr` are: 0 = control word, 1 = count, 2 = reload value. Address 3 reads as zero and ignores writes.

Top module: `ivt_timer`

## Requirements
- R1: After reset the control word reads 0, which selects divide-by-1 with counting halted. The count and reload registers read 0 and `irq_o` is low.
- R2: While the run bit (control bit 1) is set, the count decrements once every 2^S bus-clock cycles, where S is the clock-select field at control bits 5:4. The prescaler restarts whenever the run bit is clear or a control write changes S.
- R3: A tick that takes the count from 1 to 0 raises `irq_o` for exactly one cycle, starting in the cycle after that tick's clock edge.
- R4: With periodic mode off (control bit 2 = 0), the terminal event sets the flag at control bit 0. After that, the count holds at 0 and no further interrupt occurs.
- R5: The terminal-count flag stays set until a permitted read or write of the control word. That access clears it, unless a new terminal event occurs in the same cycle, in which case the flag stays set.
- R6: With periodic mode on, a tick taken at count 0 loads the reload value, and the terminal event leaves the flag unchanged.
- R7: A count write in the same cycle as a tick stores the written value, and the decrement is dropped.
- R8: When `bus_user` is high and the access-enable bit (control bit 3) is clear, writes to every register are ignored and reads return 0. When the bit is set, user accesses act like supervisor accesses.
- R9: The count register can be read and written while the timer is running.
- R10: While the run bit is clear, the count changes only through bus writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_user | input | 1 | Access is user-level |
| bus_addr | input | 2 | Register address (0 control, 1 count, 2 reload) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current request |
| irq_o | output | 1 | One-cycle terminal-count interrupt pulse |

## Verification
Several properties are checked on every cycle:
- the interrupt never lasts two cycles;
- the flag is set on one-shot terminal events, cleared by control accesses and left alone in periodic mode;
- the reload load happens at zero;
- a count write wins over a tick;
- the count freezes while halted;
- denied user accesses have no effect.

Two things only the bench scenarios can show: the tick spacing for each divide setting, and the prescaler restart on a select change. The bench shows them by comparing the count every cycle against a model under directed and random register traffic.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_COUNT  = 2'd1,
        REG_RELOAD = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    // control word bit positions
    localparam int unsigned CB_TC  = 0;
    localparam int unsigned CB_RUN = 1;
    localparam int unsigned CB_PER = 2;
    localparam int unsigned CB_UAE = 3;
    localparam int unsigned CB_SEL = 4;
endpackage

// File: rtl/ivt_access.sv
module ivt_access
    import ivt_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_user,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              user_en,
    output logic              allow,
    output logic              wr_ctrl,
    output logic              wr_count,
    output logic              wr_reload,
    output logic              ctrl_touch
);
    reg_sel_e rsel;

    always_comb begin
        rsel       = reg_sel_e'(bus_addr);
        allow      = bus_sel && (!bus_user || user_en);
        wr_ctrl    = allow && bus_wr && (rsel == REG_CTRL);
        wr_count   = allow && bus_wr && (rsel == REG_COUNT);
        wr_reload  = allow && bus_wr && (rsel == REG_RELOAD);
        ctrl_touch = allow && (bus_wr || bus_rd) && (rsel == REG_CTRL);
    end
endmodule

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int unsigned PRE_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = (PRE_W'(1) << div_sel) - PRE_W'(1);
        tick  = run && (st_q.phase == limit);
        st_d  = st_q;
        if (restart || tick) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             periodic,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count_o,
    output logic             term_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       at_zero;

    always_comb begin
        at_zero = (st_q.cnt == '0);
        term_o  = tick && !load_en && (st_q.cnt == CNT_W'(1));
        st_d    = st_q;
        if (load_en) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            if (at_zero) begin
                st_d.cnt = periodic ? reload_val : '0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
        count_o = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_user,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_o
);
    localparam int unsigned CTRL_W = CB_SEL + SEL_W;

    typedef struct packed {
        logic             run;
        logic             per;
        logic             uae;
        logic [SEL_W-1:0] sel;
        logic             tc;
        logic [CNT_W-1:0] reload;
        logic             irq;
    } top_state_t;

    top_state_t st_d, st_q;

    logic             allow, wr_ctrl, wr_count, wr_reload, mode_acc;
    logic             tick, term, sel_change, restart;
    logic [CNT_W-1:0] count_q, reload_q;
    logic             run_q, rld_q, uae_q, tc_q;
    logic [CTRL_W-1:0] ctrl_word;

    assign run_q    = st_q.run;
    assign rld_q    = st_q.per;
    assign uae_q    = st_q.uae;
    assign tc_q     = st_q.tc;
    assign reload_q = st_q.reload;
    assign irq_o    = st_q.irq;

    ivt_access u_access (
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_user   (bus_user),
        .bus_addr   (bus_addr),
        .user_en    (st_q.uae),
        .allow      (allow),
        .wr_ctrl    (wr_ctrl),
        .wr_count   (wr_count),
        .wr_reload  (wr_reload),
        .ctrl_touch (mode_acc)
    );

    ivt_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.run),
        .restart (restart),
        .div_sel (st_q.sel),
        .tick    (tick)
    );

    ivt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .periodic   (st_q.per),
        .load_en    (wr_count),
        .load_val   (bus_wdata),
        .reload_val (st_q.reload),
        .count_o    (count_q),
        .term_o     (term)
    );

    always_comb begin
        sel_change = wr_ctrl && (bus_wdata[CB_SEL +: SEL_W] != st_q.sel);
        restart    = !st_q.run || sel_change;

        st_d = st_q;
        if (wr_ctrl) begin
            st_d.run = bus_wdata[CB_RUN];
            st_d.per = bus_wdata[CB_PER];
            st_d.uae = bus_wdata[CB_UAE];
            st_d.sel = bus_wdata[CB_SEL +: SEL_W];
        end
        if (wr_reload) begin
            st_d.reload = bus_wdata;
        end
        st_d.tc  = (st_q.tc && !mode_acc) || (term && !st_q.per);
        st_d.irq = term;

        ctrl_word         = '0;
        ctrl_word[CB_TC]  = st_q.tc;
        ctrl_word[CB_RUN] = st_q.run;
        ctrl_word[CB_PER] = st_q.per;
        ctrl_word[CB_UAE] = st_q.uae;
        ctrl_word[CB_SEL +: SEL_W] = st_q.sel;

        bus_rdata = '0;
        if (allow && bus_rd) begin
            unique case (reg_sel_e'(bus_addr))
                REG_CTRL:   bus_rdata = CNT_W'(ctrl_word);
                REG_COUNT:  bus_rdata = count_q;
                REG_RELOAD: bus_rdata = st_q.reload;
                default:    bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic             bus_user,
    input logic [CNT_W-1:0] bus_wdata,
    input logic [CNT_W-1:0] bus_rdata,
    input logic             irq_o,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] reload_q,
    input logic             rld_q,
    input logic             run_q,
    input logic             uae_q,
    input logic             tc_q,
    input logic             tick,
    input logic             term,
    input logic             wr_count,
    input logic             mode_acc
);
    // R3
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R4
    tc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !rld_q) |=> tc_q);

    // R4
    park_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rld_q && count_q == '0 && !wr_count) |=> count_q == '0);

    // R5
    tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_acc && !term) |=> !tc_q);

    // R6
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rld_q && count_q == '0 && !wr_count) |=> count_q == $past(reload_q));

    // R6
    periodic_no_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term && rld_q && !tc_q) |=> !tc_q);

    // R7
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> count_q == $past(bus_wdata));

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_count) |=> $stable(count_q));

    // R8
    deny_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_user && !uae_q) |=> $stable(reload_q));

    // R8
    deny_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_rd && bus_user && !uae_q) |-> bus_rdata == '0);
endmodule

bind ivt_timer ivt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_user  (bus_user),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .count_q   (count_q),
    .reload_q  (reload_q),
    .rld_q     (rld_q),
    .run_q     (run_q),
    .uae_q     (uae_q),
    .tc_q      (tc_q),
    .tick      (tick),
    .term      (term),
    .wr_count  (wr_count),
    .mode_acc  (mode_acc)
);

// File: tb/tb_ivt_timer.sv
module tb_ivt_timer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr, bus_rd, bus_user;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    int irq_seen = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_cnt, m_rld;
    logic        m_run, m_per, m_ua, m_tc, m_irq;
    logic [1:0]  m_sel;
    int          m_pre;

    always #5 clk = ~clk;

    ivt_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_user(bus_user), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic logic [31:0] exp_ctrl();
        return {26'd0, m_sel, m_ua, m_per, m_run, m_tc};
    endfunction

    function automatic logic m_allow();
        return bus_sel && (!bus_user || m_ua);
    endfunction

    function automatic logic [31:0] exp_read();
        if (!(m_allow() && bus_rd)) return 32'd0;
        case (bus_addr)
            2'd0:    return exp_ctrl();
            2'd1:    return m_cnt;
            2'd2:    return m_rld;
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_edge();
        logic acc, wc, wm, wr_r, touch, tk, trm;
        logic [31:0] nc;
        acc   = m_allow();
        wm    = acc && bus_wr && bus_addr == 2'd0;
        wc    = acc && bus_wr && bus_addr == 2'd1;
        wr_r  = acc && bus_wr && bus_addr == 2'd2;
        touch = acc && (bus_wr || bus_rd) && bus_addr == 2'd0;
        tk    = m_run && (m_pre == (1 << m_sel) - 1);
        trm   = tk && !wc && m_cnt == 32'd1;
        nc = m_cnt;
        if (wc) nc = bus_wdata;
        else if (tk) nc = (m_cnt == 0) ? (m_per ? m_rld : 32'd0) : m_cnt - 1;
        if (!m_run || (wm && bus_wdata[5:4] != m_sel) || tk) m_pre = 0;
        else m_pre = m_pre + 1;
        m_tc  = (m_tc && !touch) || (trm && !m_per);
        m_irq = trm;
        m_cnt = nc;
        if (wr_r) m_rld = bus_wdata;
        if (wm) begin
            m_run = bus_wdata[1]; m_per = bus_wdata[2];
            m_ua  = bus_wdata[3]; m_sel = bus_wdata[5:4];
        end
    endtask

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic set_idle();
        bus_sel = 1'b1; bus_rd = 1'b1; bus_wr = 1'b0;
        bus_user = 1'b0; bus_addr = 2'd1; bus_wdata = 32'd0;
    endtask

    task automatic cycle(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        set_idle();
        #1;
        if (irq_o) irq_seen++;
        check(bus_rdata == m_cnt, tag, "count", bus_rdata, m_cnt);
        check(irq_o == m_irq, tag, "irq", {31'd0, irq_o}, {31'd0, m_irq});
    endtask

    task automatic wr_reg(logic [1:0] a, logic [31:0] d, logic u, string tag);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_rd = 1'b0;
        bus_addr = a; bus_wdata = d; bus_user = u;
        cycle(tag);
    endtask

    task automatic rd_reg(logic [1:0] a, logic u, string tag);
        logic [31:0] e;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_rd = 1'b1;
        bus_addr = a; bus_user = u;
        #1;
        e = exp_read();
        check(bus_rdata == e, tag, "readback", bus_rdata, e);
        cycle(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cycle(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        set_idle();
        m_cnt = 0; m_rld = 0; m_run = 0; m_per = 0; m_ua = 0;
        m_tc = 0; m_irq = 0; m_sel = 0; m_pre = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1: reset state
        check(irq_o == 1'b0, "R1", "irq", {31'd0, irq_o}, 32'd0);
        check(bus_rdata == 32'd0, "R1", "count", bus_rdata, 32'd0);
        rd_reg(2'd0, 1'b0, "R1");
        rd_reg(2'd2, 1'b0, "R1");

        // R2 R3 R4 R5: one-shot for each divider
        for (int s = 0; s < 4; s++) begin
            wr_reg(2'd1, 32'd5, 1'b0, "R9");
            irq_seen = 0;
            wr_reg(2'd0, (32'(s) << 4) | 32'h2, 1'b0, "R2");
            idle(5 * 8 + 6, "R2");
            check(irq_seen == 1, "R3", "irq pulses", 32'(irq_seen), 32'd1);
            check(m_tc == 1'b1, "R4", "model tc", {31'd0, m_tc}, 32'd1);
            rd_reg(2'd0, 1'b0, "R4");
            rd_reg(2'd0, 1'b0, "R5");
        end

        // R6: periodic mode
        wr_reg(2'd2, 32'd3, 1'b0, "R6");
        wr_reg(2'd1, 32'd2, 1'b0, "R6");
        irq_seen = 0;
        wr_reg(2'd0, 32'h6, 1'b0, "R6");
        idle(20, "R6");
        check(irq_seen == 5, "R6", "irq pulses", 32'(irq_seen), 32'd5);
        rd_reg(2'd0, 1'b0, "R6");

        // R7 R9: writes while running at full rate
        for (int i = 0; i < 6; i++) wr_reg(2'd1, 32'd10 + 32'(i), 1'b0, "R7");
        wr_reg(2'd1, 32'hFFFF_FFFF, 1'b0, "R9");
        idle(3, "R9");

        // R10: halted
        wr_reg(2'd0, 32'h0, 1'b0, "R10");
        wr_reg(2'd1, 32'd7, 1'b0, "R10");
        idle(10, "R10");

        // R8: user gating
        wr_reg(2'd2, 32'h55, 1'b1, "R8");
        rd_reg(2'd2, 1'b0, "R8");
        rd_reg(2'd1, 1'b1, "R8");
        wr_reg(2'd0, 32'h2, 1'b1, "R8");
        rd_reg(2'd0, 1'b0, "R8");
        wr_reg(2'd0, 32'h8, 1'b0, "R8");
        wr_reg(2'd2, 32'h66, 1'b1, "R8");
        rd_reg(2'd2, 1'b1, "R8");

        // R5: tc set and cleared by a control write
        wr_reg(2'd1, 32'd2, 1'b0, "R5");
        wr_reg(2'd0, 32'h2, 1'b0, "R5");
        idle(4, "R5");
        rd_reg(2'd0, 1'b0, "R5");
        wr_reg(2'd0, 32'h2, 1'b0, "R5");
        rd_reg(2'd0, 1'b0, "R5");

        // random traffic across R2 R3 R6 R7
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 68) begin
                cycle("R2_R3");
            end else if (r < 78) begin
                wr_reg(2'd1, $urandom % 24, ($urandom % 5) == 0, "R7");
            end else if (r < 83) begin
                wr_reg(2'd2, $urandom % 16, ($urandom % 5) == 0, "R6");
            end else if (r < 90) begin
                logic [31:0] d;
                d = {26'd0, 2'($urandom), 1'($urandom), 1'($urandom),
                     ($urandom % 4) != 0, 1'($urandom)};
                wr_reg(2'd0, d, ($urandom % 5) == 0, "R2");
            end else if (r < 95) begin
                rd_reg(2'd0, ($urandom % 4) == 0, "R5");
            end else begin
                rd_reg(2'($urandom), 1'($urandom), "R8");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule